// File: doc/BRIEF.md
# Small-Page NAND Read Pointer and Column Engine

This block models the device side of a small-page NAND flash during reads. It samples the host strobes on a fast internal clock: chip enable, command latch, address latch, write strobe and read strobe. A command byte, or a three-byte address, is captured on the rising edge of the write strobe. A read pointer chooses one of three areas: the first half of the main array, the second half of the main array, or the spare bytes. The block sets the starting column of the page register from that pointer and the first address byte.

When the third address byte arrives, the block starts a modelled page transfer. Ready/busy is held low for a fixed number of clocks. After that, each falling edge of the read strobe returns the page-register byte at the current column, and the column moves forward until it reaches the last byte of the selected area. Page-register contents are not stored here. The block presents a page number and a column, and the surrounding model returns the byte combinationally.

Top module: `nand_read_ptr`

## Requirements
- R1: After reset the pointer selects the first main half, rb is 1 and io_oe is 0.
- R2: Three address bytes written with ale=1 set the start column from byte 1 and the page from bytes 2 (low) and 3 (high). With the first-half pointer, the start column equals byte 1.
- R3: Once the third address byte is latched, rb goes to 0 and stays there for exactly TR_CYCLES clocks. Read strobe falls while rb=0 change neither io_out nor the column.
- R4: Each falling edge of re_n while rb=1 presents the byte of the current column, starting at the start column, and then moves the column forward by one.
- R5: With a main pointer the column stops at 511. Further read strobes repeat byte 511 and do not wrap.
- R6: Command 01h makes the next address sequence start at column 256 plus byte 1. The address sequence after that, issued without a command, uses the first half again.
- R7: Command 50h selects the spare area. The start column is 512 plus bits 3:0 of byte 1, bits 7:4 are ignored, and reading stops and repeats at column 527.
- R8: The spare pointer persists across address sequences issued without a command, until command 00h returns it to the first main half.
- R9: After command 00h, further address sequences issued without a command keep reading from the first main half.
- R10: io_oe is 1 only while ce_n and re_n are both 0.
- R11: Write strobes with ce_n=1 change neither the pointer nor the address state, and do not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, latches on its rising edge |
| re_n | input | 1 | Read strobe, outputs a byte on its falling edge |
| io_in | input | 8 | Command/address byte from the host |
| io_out | output | 8 | Data byte to the host |
| io_oe | output | 1 | Output enable for io_out |
| rb | output | 1 | Ready (1) / busy (0) |
| mem_page | output | 16 | Page number presented to the page-register model |
| mem_col | output | 10 | Column presented to the page-register model |
| mem_data | input | 8 | Byte returned by the page-register model |

## Verification
Page contents are a mixing function of page and column, so a wrong page, a wrong column or a wrong area offset each produce a distinct byte. Reading the whole first half from column 0, plus extra strobes past 511, separates correct stepping from wrapping or early stopping. Second-half reads that run into column 511, followed by a read issued without a command, show both the 256 offset and its return to the first half. An exhaustive sweep of all sixteen spare start nibbles, each with junk in the upper nibble, checks the masking and the hold at 527. Strobes with chip enable high, and read strobes during busy, show that those inputs leave the state untouched.

// File: rtl/nand_read_ptr.sv
module nand_read_ptr #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int TR_CYCLES   = 20,
  parameter int COL_W       = $clog2(MAIN_BYTES + SPARE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cle,
  input  logic             ale,
  input  logic             we_n,
  input  logic             re_n,
  input  logic [7:0]       io_in,
  output logic [7:0]       io_out,
  output logic             io_oe,
  output logic             rb,
  output logic [15:0]      mem_page,
  output logic [COL_W-1:0] mem_col,
  input  logic [7:0]       mem_data
);
  localparam int HALF       = MAIN_BYTES / 2;
  localparam int MAIN_LAST  = MAIN_BYTES - 1;
  localparam int SPARE_LAST = MAIN_BYTES + SPARE_BYTES - 1;
  localparam int SP_BITS    = $clog2(SPARE_BYTES);
  localparam int BW         = $clog2(TR_CYCLES + 1);

  localparam logic [1:0] PTR_LO = 2'd0, PTR_HI = 2'd1, PTR_SP = 2'd2;

  logic             we_q, re_q;
  logic [1:0]       ptr, area, acnt;
  logic [7:0]       col_lat, dout;
  logic [15:0]      page;
  logic [COL_W-1:0] col, last, start_col;
  logic [BW-1:0]    busy;

  wire we_rise = !we_q && we_n && !ce_n;
  wire re_fall = re_q && !re_n && !ce_n;
  wire cmd_wr  = we_rise && cle && !ale;
  wire adr_wr  = we_rise && ale && !cle;
  wire start   = adr_wr && acnt == 2'd2;

  assign last     = (area == PTR_SP) ? COL_W'(SPARE_LAST) : COL_W'(MAIN_LAST);
  assign io_oe    = !ce_n && !re_n;
  assign io_out   = dout;
  assign rb       = busy == '0;
  assign mem_page = page;
  assign mem_col  = col;

  always_comb begin
    case (ptr)
      PTR_HI:  start_col = COL_W'(HALF) + COL_W'(col_lat);
      PTR_SP:  start_col = COL_W'(MAIN_BYTES) + COL_W'(col_lat[SP_BITS-1:0]);
      default: start_col = COL_W'(col_lat);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1; re_q <= 1'b1;
      ptr <= PTR_LO; area <= PTR_LO; acnt <= '0;
      col_lat <= '0; page <= '0; col <= '0; dout <= '0; busy <= '0;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
      if (busy != '0) busy <= busy - 1'b1;
      if (cmd_wr) begin
        acnt <= '0;
        case (io_in)
          8'h00: ptr <= PTR_LO;
          8'h01: ptr <= PTR_HI;
          8'h50: ptr <= PTR_SP;
          default: ;
        endcase
      end
      if (adr_wr) begin
        case (acnt)
          2'd0:    col_lat <= io_in;
          2'd1:    page[7:0] <= io_in;
          default: page[15:8] <= io_in;
        endcase
        acnt <= start ? 2'd0 : acnt + 2'd1;
      end
      if (start) begin
        area <= ptr;
        col  <= start_col;
        busy <= BW'(TR_CYCLES);
        if (ptr == PTR_HI) ptr <= PTR_LO;
      end else if (re_fall && rb) begin
        dout <= mem_data;
        if (col != last) col <= col + 1'b1;
      end
    end
  end
endmodule

module nand_read_ptr_chk #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int TR_CYCLES   = 20,
  parameter int COL_W       = 10,
  parameter int BW          = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rb,
  input logic [7:0]       io_out,
  input logic [1:0]       ptr,
  input logic [1:0]       area,
  input logic [COL_W-1:0] col,
  input logic [BW-1:0]    busy,
  input logic             re_fall
);
  logic [COL_W-1:0] lastv;
  assign lastv = (area == 2'd2) ? COL_W'(MAIN_BYTES + SPARE_BYTES - 1) : COL_W'(MAIN_BYTES - 1);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rb && ptr == 2'd0));
  assert_busy_holds_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb && $past(!rb)) |-> $stable(io_out));
  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy <= BW'(TR_CYCLES));
  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (re_fall && rb && col != lastv) |=> (col == $past(col) + 1'b1 || !rb));
  assert_main_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (area != 2'd2) |-> col <= COL_W'(MAIN_BYTES - 1));
  assert_hi_reverts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rb && $past(!rb)) |-> ptr != 2'd1);
  assert_spare_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (area == 2'd2) |-> (col >= COL_W'(MAIN_BYTES) && col <= lastv));
endmodule

bind nand_read_ptr nand_read_ptr_chk #(
  .MAIN_BYTES(MAIN_BYTES), .SPARE_BYTES(SPARE_BYTES), .TR_CYCLES(TR_CYCLES),
  .COL_W(COL_W), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rb(rb), .io_out(io_out), .ptr(ptr), .area(area),
  .col(col), .busy(busy), .re_fall(re_fall)
);

// File: tb/nand_read_ptr_bench.sv
module nand_read_ptr_bench;
  localparam int TR = 20;
  logic clk = 0, rst_n = 0, ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1;
  logic [7:0] io_in = 0, io_out, mem_data;
  logic io_oe, rb;
  logic [15:0] mem_page;
  logic [9:0] mem_col;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pbyte(input logic [15:0] p, input int c);
    logic [9:0] cc = 10'(c);
    return p[7:0] * 8'd37 + p[15:8] + cc[7:0] * 8'd5 + {6'd0, cc[9:8]} * 8'd91;
  endfunction

  assign mem_data = pbyte(mem_page, int'(mem_col));

  nand_read_ptr #(.TR_CYCLES(TR)) u_nand_read_ptr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb(rb),
    .mem_page(mem_page), .mem_col(mem_col), .mem_data(mem_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; io_in = b; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic addr3(input logic [7:0] c, input logic [15:0] p);
    wr(0, 1, c); wr(0, 1, p[7:0]); wr(0, 1, p[15:8]);
  endtask

  task automatic wait_ready(input string req, input bit count_it);
    int n = 0;
    chk(rb == 0, req, rb, 0);
    while (!rb && n < 1000) begin @(negedge clk); n++; end
    if (count_it) chk(n == TR, req, n, TR);
  endtask

  task automatic rd(input logic [7:0] exp, input string req);
    @(negedge clk); re_n = 0;
    @(negedge clk);
    chk(io_oe == 1 && io_out == exp, req, io_out, exp);
    re_n = 1;
  endtask

  task automatic run(input int s, input int last, input int n, input logic [15:0] p, input string req);
    for (int i = 0; i < n; i++) rd(pbyte(p, (s + i > last) ? last : s + i), req);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rb == 1, "R1 rb", rb, 1);
    chk(io_oe == 0, "R1 oe", io_oe, 0);
    ce_n = 0;
    @(negedge clk);
    chk(io_oe == 0, "R10 re high", io_oe, 0);

    // R1/R2/R4/R5: default pointer, full first half, run past the end
    addr3(8'h00, 16'h1234);
    wait_ready("R3 busy length", 1);
    run(0, 511, 515, 16'h1234, "R2 R4 R5 main sweep");

    // R10: ce high with re low drives nothing
    @(negedge clk); ce_n = 1; re_n = 0;
    @(negedge clk); chk(io_oe == 0, "R10 ce high", io_oe, 0);
    re_n = 1; ce_n = 0;

    // R3: read strobes during busy are ignored
    held = pbyte(16'h1234, 511);
    addr3(8'h05, 16'h0042);
    rd(held, "R3 out frozen");
    rd(held, "R3 out frozen");
    wait_ready("R3", 0);
    run(5, 511, 4, 16'h0042, "R3 R2 column untouched");

    // R6: second half, then automatic return
    wr(1, 0, 8'h01);
    addr3(8'h10, 16'h0007);
    wait_ready("R6", 0);
    run(256 + 16, 511, 3, 16'h0007, "R6 second half");
    wr(1, 0, 8'h01);
    addr3(8'hFA, 16'h0107);
    wait_ready("R6", 0);
    run(256 + 250, 511, 9, 16'h0107, "R6 R5 second half end");
    addr3(8'h10, 16'h0008);
    wait_ready("R6", 0);
    run(16, 511, 3, 16'h0008, "R6 reverted");

    // R9: address-only reads stay in first half
    for (int k = 0; k < 4; k++) begin
      addr3(8'(k * 60 + 3), 16'(16'h0900 + k));
      wait_ready("R9", 0);
      run(k * 60 + 3, 511, 2, 16'(16'h0900 + k), "R9 sticky first half");
    end

    // R7: spare, every start nibble with junk upper nibble
    wr(1, 0, 8'h50);
    for (int n = 0; n < 16; n++) begin
      addr3({4'(15 - n), 4'(n)}, 16'(16'h2200 + n));
      wait_ready("R7", 0);
      run(512 + n, 527, 16 - n + 2, 16'(16'h2200 + n), "R7 spare sweep");
    end

    // R8: spare sticky until 00h
    addr3(8'h03, 16'h0033);
    wait_ready("R8", 0);
    run(515, 527, 2, 16'h0033, "R8 spare sticky");
    wr(1, 0, 8'h00);
    addr3(8'h03, 16'h0034);
    wait_ready("R8", 0);
    run(3, 511, 2, 16'h0034, "R8 back to main");

    // R11: strobes with ce high are ignored
    ce_n = 1;
    wr(1, 0, 8'h50);
    wr(1, 0, 8'h01);
    addr3(8'h20, 16'h0055);
    @(negedge clk);
    chk(rb == 1, "R11 no transfer", rb, 1);
    ce_n = 0;
    run(5, 511, 1, 16'h0034, "R11 state kept");
    addr3(8'h07, 16'h0056);
    wait_ready("R11", 0);
    run(7, 511, 2, 16'h0056, "R11 pointer kept");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule